// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

A 32-bit timer that counts down from a software-written value and flags each expiry. A small register port gives write and read access to four registers: the reload value, the live count, a control word and an event status word. Decrements are paced by an 8-bit prescaler. When the count expires, the timer either restarts from the reload value or parks at zero. Each expiry sets a sticky event bit, which software clears by writing a one to it. A level interrupt output follows that bit, gated by an enable in the control word.

The count is held in a three-state machine:
- RUN: the count is nonzero and decrementing.
- EXPIRED: the count reached zero by decrementing, and the event has already been raised.
- ZERO_ARMED: zero was written to the count, or reloaded into it, and no event has been raised for it yet.

The transitions are:
- RUN to EXPIRED on the tick that takes the count from 1 to 0.
- EXPIRED to RUN or to ZERO_ARMED on a tick with auto-reload set. This reload raises no event.
- ZERO_ARMED to RUN or to ZERO_ARMED on a tick with auto-reload set. This reload raises an event.
- Any state to RUN or to ZERO_ARMED on a write to the count, chosen by whether the written value is zero.

Top module: `tmr_down_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The count changes only while control bit 0 (enable) is 1, apart from register writes.
- R3: Control bits [15:8] hold a prescale value P. One decrement occurs every P+1 clock cycles while enabled. A write to the load or count register restarts the prescale phase, so the next decrement comes P+1 cycles after that write.
- R4: With control bit 1 (auto-reload) clear, the tick taking the count from 1 to 0 sets status bit 0. The count then stays at 0.
- R5: With auto-reload set, the tick after the count reaches zero reloads the load value. That reload does not set the event bit again, so there is exactly one event per expiry.
- R6: If zero was written to the count, a tick with auto-reload set reloads the count and sets the event bit. Without auto-reload, the count stays at 0 and no event is raised.
- R7: Writing offset 0x0 (load) sets both the load register and the count. Writing offset 0x4 (count) sets only the count. The count written takes effect on the clock edge of the write.
- R8: The control register at offset 0x8 reads back bits 0, 1, 2 and [15:8]. All other bits read as 0.
- R9: Status offset 0xC bit 0 is sticky. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when status bit 0 is 1 and control bit 2 (interrupt enable) is 1.
- R11: A write in the same cycle as an expiry takes priority: a write of 1 to status bit 0 leaves the bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The table-driven pass runs the timer with several combinations of prescale value, reload value, reload mode and elapsed time. The one-shot rows tell apart a count stopped before zero from one parked at zero. The auto-reload rows catch off-by-one errors in the reload period, since the count lands either on the reload value or mid-period. Large prescale values expose a mis-sized tick period. Directed cases separate the two ways of reaching zero: a decrement raises the event at once, while a written zero raises it only on the reload. They also show that a write overrides a tick or an expiry in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CNT_RUN        = 2'd0,
        CNT_EXPIRED    = 2'd1,
        CNT_ZERO_ARMED = 2'd2
    } cnt_state_e;

    // register index = byte offset [3:2]
    localparam logic [1:0] REG_LOAD   = 2'd0;
    localparam logic [1:0] REG_COUNT  = 2'd1;
    localparam logic [1:0] REG_CTRL   = 2'd2;
    localparam logic [1:0] REG_STATUS = 2'd3;

    // control word bit positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_AUTO_BIT  = 1;
    localparam int CTL_IE_BIT    = 2;
    localparam int CTL_PRESC_LSB = 8;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] limit,
    output logic               tick
);
    logic [PRESC_W-1:0] phase_q;

    always_comb begin
        tick = run && !restart && (phase_q == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             set_valid,
    input  logic [CNT_W-1:0] set_value,
    input  logic             auto_rl,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_ZERO_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (set_valid) begin
            cnt_d   = set_value;
            state_d = (set_value == '0) ? CNT_ZERO_ARMED : CNT_RUN;
        end else if (tick) begin
            unique case (state_q)
                CNT_RUN: begin
                    if (cnt_q <= CNT_W'(1)) begin
                        cnt_d   = '0;
                        state_d = CNT_EXPIRED;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                CNT_EXPIRED, CNT_ZERO_ARMED: begin
                    if (auto_rl) begin
                        cnt_d   = reload_val;
                        state_d = (reload_val == '0) ? CNT_ZERO_ARMED : CNT_RUN;
                    end
                end
                default: begin
                    cnt_d   = '0;
                    state_d = CNT_ZERO_ARMED;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        zero_evt = 1'b0;
        if (!set_valid && tick) begin
            unique case (state_q)
                CNT_RUN:        zero_evt = (cnt_q <= CNT_W'(1));
                CNT_ZERO_ARMED: zero_evt = auto_rl;
                default:        zero_evt = 1'b0;
            endcase
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  count,
    input  logic               zero_evt,
    output logic [DATA_W-1:0]  load_val,
    output logic               ctl_en,
    output logic               ctl_auto,
    output logic               ctl_ie,
    output logic [PRESC_W-1:0] ctl_presc,
    output logic               cnt_set,
    output logic               evt_flag
);
    localparam int PRESC_MSB = CTL_PRESC_LSB + PRESC_W - 1;

    logic [1:0] reg_sel;
    logic       wr_load, wr_count, wr_ctrl, wr_status;

    always_comb begin
        reg_sel   = bus_addr[3:2];
        wr_load   = bus_wr && (reg_sel == REG_LOAD);
        wr_count  = bus_wr && (reg_sel == REG_COUNT);
        wr_ctrl   = bus_wr && (reg_sel == REG_CTRL);
        wr_status = bus_wr && (reg_sel == REG_STATUS);
        cnt_set   = wr_load || wr_count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_val  <= '0;
            ctl_en    <= 1'b0;
            ctl_auto  <= 1'b0;
            ctl_ie    <= 1'b0;
            ctl_presc <= '0;
        end else begin
            if (wr_load) begin
                load_val <= bus_wdata;
            end
            if (wr_ctrl) begin
                ctl_en    <= bus_wdata[CTL_EN_BIT];
                ctl_auto  <= bus_wdata[CTL_AUTO_BIT];
                ctl_ie    <= bus_wdata[CTL_IE_BIT];
                ctl_presc <= bus_wdata[PRESC_MSB:CTL_PRESC_LSB];
            end
        end
    end

    // sticky event bit: a one-write clear outranks a same-cycle expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_flag <= 1'b0;
        end else if (wr_status && bus_wdata[0]) begin
            evt_flag <= 1'b0;
        end else if (zero_evt) begin
            evt_flag <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel)
            REG_LOAD:  bus_rdata = load_val;
            REG_COUNT: bus_rdata = count;
            REG_CTRL: begin
                bus_rdata[CTL_EN_BIT]              = ctl_en;
                bus_rdata[CTL_AUTO_BIT]            = ctl_auto;
                bus_rdata[CTL_IE_BIT]              = ctl_ie;
                bus_rdata[PRESC_MSB:CTL_PRESC_LSB] = ctl_presc;
            end
            REG_STATUS: bus_rdata[0] = evt_flag;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_down_timer.sv
module tmr_down_timer #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int PRESC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0]  load_val;
    logic [DATA_W-1:0]  count;
    logic               ctl_en, ctl_auto, ctl_ie;
    logic [PRESC_W-1:0] ctl_presc;
    logic               cnt_set;
    logic               evt_flag;
    logic               zero_evt;
    logic               tick;

    tmr_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PRESC_W(PRESC_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .count    (count),
        .zero_evt (zero_evt),
        .load_val (load_val),
        .ctl_en   (ctl_en),
        .ctl_auto (ctl_auto),
        .ctl_ie   (ctl_ie),
        .ctl_presc(ctl_presc),
        .cnt_set  (cnt_set),
        .evt_flag (evt_flag)
    );

    tmr_prescaler #(
        .PRESC_W(PRESC_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl_en),
        .restart(cnt_set),
        .limit  (ctl_presc),
        .tick   (tick)
    );

    tmr_count_fsm #(
        .CNT_W(DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .set_valid (cnt_set),
        .set_value (bus_wdata),
        .auto_rl   (ctl_auto),
        .reload_val(load_val),
        .count     (count),
        .zero_evt  (zero_evt)
    );

    assign irq = evt_flag && ctl_ie;
endmodule

// File: rtl/tmr_down_timer_chk.sv
module tmr_down_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              tick,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] load_val,
    input logic              evt_flag,
    input logic              ctl_en,
    input logic              ctl_ie
);
    logic wr_cnt_any, wr_ld, wr_st1;
    assign wr_ld      = bus_wr && (bus_addr[3:2] == 2'd0);
    assign wr_cnt_any = bus_wr && (bus_addr[3:2] <= 2'd1);
    assign wr_st1     = bus_wr && (bus_addr[3:2] == 2'd3) && bus_wdata[0];

    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !wr_cnt_any) |=> count == $past(count));

    a_r3_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !tick);

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt_any && count > DATA_W'(1)) |=> count == $past(count) - 1'b1);

    a_r4_event_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> $past(tick));

    a_r7_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ld |=> (count == $past(bus_wdata) && load_val == $past(bus_wdata)));

    a_r9_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_st1 |=> !evt_flag);

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt_flag);

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ie |-> !irq);
endmodule

bind tmr_down_timer tmr_down_timer_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq      (irq),
    .tick     (tick),
    .count    (count),
    .load_val (load_val),
    .evt_flag (evt_flag),
    .ctl_en   (ctl_en),
    .ctl_ie   (ctl_ie)
);

// File: tb/tb_tmr_down_timer.sv
`timescale 1ns/1ps
module tb_tmr_down_timer;
    localparam logic [3:0] A_LOAD = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_ST = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_down_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  presc;
        logic [31:0] load;
        logic        auto_rl;
        logic [15:0] edges;
        logic [31:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    // prescale, load, auto, edges after enable, expected count, expected flag
    localparam vec_t VECS [10] = '{
        '{8'd0,   32'd5,  1'b0, 16'd3,   32'd2,  1'b0},
        '{8'd0,   32'd5,  1'b0, 16'd5,   32'd0,  1'b1},
        '{8'd0,   32'd5,  1'b0, 16'd9,   32'd0,  1'b1},
        '{8'd3,   32'd4,  1'b0, 16'd8,   32'd2,  1'b0},
        '{8'd3,   32'd4,  1'b0, 16'd16,  32'd0,  1'b1},
        '{8'd0,   32'd3,  1'b1, 16'd4,   32'd3,  1'b1},
        '{8'd0,   32'd3,  1'b1, 16'd6,   32'd1,  1'b1},
        '{8'd1,   32'd3,  1'b1, 16'd5,   32'd1,  1'b0},
        '{8'd255, 32'd2,  1'b0, 16'd512, 32'd0,  1'b1},
        '{8'd2,   32'd10, 1'b1, 16'd33,  32'd10, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // called right after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(1);

        // R1 reset state
        rd(A_LOAD, v); chk("R1 load", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_CTL, v);  chk("R1 ctrl", v, 0);
        rd(A_ST, v);   chk("R1 status", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R8 reserved control bits
        wr(A_CTL, 32'hFFFF_FFF8);
        rd(A_CTL, v); chk("R8 ctrl readback", v, 32'h0000_FF00);
        wr(A_CTL, 32'h0);

        // R2 disabled, R7 load copies into count
        wr(A_LOAD, 32'd7);
        wait_edges(10);
        rd(A_CNT, v);  chk("R2 count held", v, 7);
        rd(A_LOAD, v); chk("R7 load", v, 7);

        // table of vectors: R3 R4 R5 R10
        for (int i = 0; i < 10; i++) begin
            wr(A_CTL, 32'h0);
            wr(A_LOAD, VECS[i].load);
            wr(A_ST, 32'h1);
            wr(A_CTL, {16'b0, VECS[i].presc, 5'b0, 1'b1, VECS[i].auto_rl, 1'b1});
            wait_edges(int'(VECS[i].edges));
            rd(A_CNT, v); chk($sformatf("R3/R4/R5 vec%0d count", i), v, VECS[i].exp_cnt);
            rd(A_ST, v);  chk($sformatf("R4/R5 vec%0d flag", i), v, {31'b0, VECS[i].exp_flag});
            chk($sformatf("R10 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_flag});
        end

        // R7 count write while running
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd10);
        wr(A_CTL, 32'h1);
        wait_edges(3);
        rd(A_CNT, v); chk("R7 before count write", v, 7);
        wr(A_CNT, 32'd20);
        rd(A_CNT, v); chk("R7 count write", v, 20);
        wait_edges(2);
        rd(A_CNT, v); chk("R7 after count write", v, 18);
        rd(A_LOAD, v); chk("R7 load unchanged", v, 10);
        wr(A_LOAD, 32'd15);
        rd(A_CNT, v); chk("R7 load write sets count", v, 15);

        // R3 prescale restart on count write
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd10);
        wr(A_CTL, 32'h301);
        wait_edges(3);
        rd(A_CNT, v); chk("R3 no tick yet", v, 10);
        wr(A_CNT, 32'd10);
        rd(A_CNT, v); chk("R3 write beats tick", v, 10);
        wait_edges(3);
        rd(A_CNT, v); chk("R3 phase restarted", v, 10);
        wait_edges(1);
        rd(A_CNT, v); chk("R3 tick after restart", v, 9);

        // R4 one-shot, R10 masking, R9 clear semantics
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd2);
        wr(A_ST, 32'h1);
        wr(A_CTL, 32'h1);
        wait_edges(3);
        rd(A_CNT, v); chk("R4 stays zero", v, 0);
        rd(A_ST, v);  chk("R4 flag set", v, 1);
        chk("R10 irq masked", {31'b0, irq}, 0);
        wr(A_ST, 32'h0);
        rd(A_ST, v);  chk("R9 zero write ignored", v, 1);
        wr(A_CTL, 32'h5);
        chk("R10 irq enabled", {31'b0, irq}, 1);
        wr(A_ST, 32'h1);
        rd(A_ST, v);  chk("R9 one write clears", v, 0);
        chk("R10 irq drops", {31'b0, irq}, 0);

        // R11 clear in the same cycle as expiry
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd2);
        wr(A_ST, 32'h1);
        wr(A_CTL, 32'h1);
        wait_edges(1);
        wr(A_ST, 32'h1);
        rd(A_CNT, v); chk("R11 count expired", v, 0);
        rd(A_ST, v);  chk("R11 clear wins", v, 0);

        // R5 reload after expiry raises no second event
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd3);
        wr(A_ST, 32'h1);
        wr(A_CTL, 32'h103);
        wait_edges(6);
        rd(A_CNT, v); chk("R5 reached zero", v, 0);
        rd(A_ST, v);  chk("R5 event", v, 1);
        wr(A_ST, 32'h1);
        wait_edges(1);
        rd(A_CNT, v); chk("R5 reloaded", v, 3);
        rd(A_ST, v);  chk("R5 no extra event", v, 0);

        // R6 written zero
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd5);
        wr(A_CNT, 32'd0);
        wr(A_ST, 32'h1);
        wr(A_CTL, 32'h1);
        wait_edges(4);
        rd(A_CNT, v); chk("R6 one-shot zero stays", v, 0);
        rd(A_ST, v);  chk("R6 one-shot no event", v, 0);
        wr(A_CTL, 32'h3);
        wait_edges(1);
        rd(A_CNT, v); chk("R6 auto reload", v, 5);
        rd(A_ST, v);  chk("R6 auto event", v, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule